// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block is a single DMA channel that copies 32-bit words from one fixed local FIFO location into host memory. It follows a chain of descriptors held in the same memory it writes. Each descriptor occupies four consecutive words, in this order: host destination address, local source address, byte count and link word. The link word's upper bits give the address of the next descriptor, and its low nibble carries flags.

Software writes the address of the first descriptor into the head register and then sets enable together with start. From then on the engine runs with no further attention. It fetches a descriptor and moves words only when the source says it has one. At the end of each descriptor it can latch an interrupt, and it then follows the link. A link that points back to an earlier descriptor forms an endless ring, which runs until software aborts it or drops enable.

The register port has four word slots, selected by `cfg_addr`:
- Slot 0 is control and status. On a write, bit 0 is enable, bit 1 is start, bit 2 clears the interrupt and bit 3 aborts. On a read, bit 0 is enable, bit 4 is the interrupt and bit 5 is busy.
- Slot 1 is the head pointer.
- Slot 2 is the current host address.
- Slot 3 is the current descriptor address.

Read data appears one cycle after the address is presented.

Top module: `desc_ring_dma`

## Requirements
- R1: After reset, `irq`, `mem_rd`, `mem_wr` and `src_pop` are 0, and slot 0 reads 0.
- R2: Software can start the engine only from idle. It writes the head pointer (slot 1, whose low 4 bits are ignored) and then writes slot 0 with bits 0 and 1 set. After that, slot 0 reads enable=1 and busy=1. The engine reads the four descriptor words at the pointer, +4, +8 and +12.
- R3: Each moved word is written to the descriptor's host address, and the address rises by 4 for every word.
- R4: The engine pops a word (`src_pop`) only in a cycle where `src_ready` is 1. Each pop produces exactly one `mem_wr` on the following cycle, and that write carries the popped `src_data`.
- R5: `src_addr` presents the descriptor's local address. It does not change while that descriptor's words are moving.
- R6: When the last word of a descriptor has been written, `irq` (also readable as slot 0 bit 4) is set if bit 2 of that descriptor's link word is 1. If bit 2 is 0, `irq` does not change.
- R7: `irq` stays set until a slot 0 write with bit 2 = 1. A slot 0 write with bit 2 = 0 leaves it set.
- R8: A descriptor whose byte count (bits 16:2 give the word count) is zero moves no words. The engine goes straight on to the next descriptor.
- R9: The low 4 bits of the link word are flags, and they are cleared to form the next descriptor address. Bit 0 means "descriptor in host memory", bit 2 requests the terminal-count interrupt and bit 3 means "local to host".
- R10: A link that points back to an earlier descriptor keeps the chain running around the ring with no end.
- R11: A slot 0 write with bit 3 = 1, or with bit 0 = 0, stops the engine at the next clock edge. After that, enable and busy read 0 and no pop or write occurs, even when `src_ready` is held high.
- R12: Slot 2 returns the host address that the next moved word would use.
- R13: A terminal-count set and a clear write in the same cycle leave `irq` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register slot select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the slot selected on the previous cycle |
| irq | output | 1 | Latched terminal-count interrupt |
| mem_rd | output | 1 | Memory read request (data returns one cycle later) |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| src_ready | input | 1 | Source has a word available |
| src_data | input | DATA_W | Source word |
| src_pop | output | 1 | Word taken from the source this cycle |
| src_addr | output | ADDR_W | Fixed local address of the current descriptor |

## Verification
Two functions can fall in the same cycle: the engine latching a terminal-count interrupt, and software writing the clear bit. The bench provokes the clash deliberately. It watches for the write of a flagged descriptor's final word, because that write is visible during the cycle whose closing edge sets the interrupt, and it drives the clear strobe into that same cycle on alternate laps of the ring. It then requires `irq` to read 1 on the following cycle. On the other laps the clear is issued a cycle later and `irq` must fall.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_TERM
  } ring_state_e;

  // control write / status read bit positions in slot 0
  localparam int CB_EN    = 0;
  localparam int CB_START = 1;
  localparam int CB_CLR   = 2;
  localparam int CB_ABORT = 3;
  localparam int SB_IRQ   = 4;
  localparam int SB_BUSY  = 5;

  // link-word flag carrying the terminal-count interrupt request
  localparam int NF_IRQ = 2;

  // register slots
  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_HEAD = 2'd1;
  localparam logic [1:0] RG_HOST = 2'd2;
  localparam logic [1:0] RG_DESC = 2'd3;

  localparam int DESC_WORDS = 4;

endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  input  logic [ADDR_W-1:0] cur_host,
  input  logic [ADDR_W-1:0] cur_desc,
  input  logic              tc_set,
  output logic              run_en,
  output logic              start_req,
  output logic              abort_req,
  output logic [ADDR_W-1:0] first_desc,
  output logic              irq,
  output logic [31:0]       cfg_rdata
);

  logic ctl_wr;
  logic clear_req;

  assign ctl_wr    = cfg_we && (cfg_addr == RG_CTRL);
  assign abort_req = ctl_wr && cfg_wdata[CB_ABORT];
  assign clear_req = ctl_wr && cfg_wdata[CB_CLR];
  assign start_req = ctl_wr && cfg_wdata[CB_EN] && cfg_wdata[CB_START]
                     && !cfg_wdata[CB_ABORT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en     <= 1'b0;
      irq        <= 1'b0;
      first_desc <= '0;
      cfg_rdata  <= '0;
    end else begin
      if (ctl_wr)
        run_en <= cfg_wdata[CB_EN] && !cfg_wdata[CB_ABORT];
      // a terminal count in the same cycle as a clear keeps the flag
      if (tc_set)
        irq <= 1'b1;
      else if (clear_req)
        irq <= 1'b0;
      if (cfg_we && (cfg_addr == RG_HEAD))
        first_desc <= cfg_wdata[ADDR_W-1:0];
      unique case (cfg_addr)
        RG_CTRL: begin
          cfg_rdata          <= '0;
          cfg_rdata[CB_EN]   <= run_en;
          cfg_rdata[SB_IRQ]  <= irq;
          cfg_rdata[SB_BUSY] <= busy;
        end
        RG_HEAD: cfg_rdata <= 32'(first_desc);
        RG_HOST: cfg_rdata <= 32'(cur_host);
        default: cfg_rdata <= 32'(cur_desc);
      endcase
    end
  end

endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              start_req,
  input  logic              abort_req,
  input  logic [ADDR_W-1:0] first_desc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_pop,
  output logic [ADDR_W-1:0] src_addr,
  output logic              tc_set,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_host,
  output logic [ADDR_W-1:0] cur_desc
);

  localparam int WC_W = CNT_W - 2;
  localparam int IC_W = $clog2(DESC_WORDS) + 1;
  localparam int RC_W = $clog2(DESC_WORDS);
  localparam int STEP = DATA_W / 8;

  ring_state_e       state;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] host;
  logic [ADDR_W-1:0] loc;
  logic [ADDR_W-5:0] nxt_base;
  logic              nxt_irq;
  logic [WC_W-1:0]   remw;
  logic [IC_W-1:0]   icnt;
  logic [RC_W-1:0]   rcnt;
  logic              rd_v;
  logic              halt;

  assign halt     = (state != ST_IDLE) && (abort_req || !run_en);
  assign src_pop  = (state == ST_XFER) && src_ready && !halt;
  assign tc_set   = (state == ST_TERM) && nxt_irq;
  assign busy     = (state != ST_IDLE);
  assign src_addr = loc;
  assign cur_host = host;
  assign cur_desc = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      host      <= '0;
      loc       <= '0;
      nxt_base  <= '0;
      nxt_irq   <= 1'b0;
      remw      <= '0;
      icnt      <= '0;
      rcnt      <= '0;
      rd_v      <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      rd_v   <= mem_rd && !halt;
      if (halt) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start_req) begin
              ptr   <= {first_desc[ADDR_W-1:4], 4'b0000};
              icnt  <= '0;
              rcnt  <= '0;
              state <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            if (icnt != IC_W'(DESC_WORDS)) begin
              mem_rd   <= 1'b1;
              mem_addr <= ptr + (ADDR_W'(icnt) << 2);
              icnt     <= icnt + 1'b1;
            end
            if (rd_v) begin
              rcnt <= rcnt + 1'b1;
              unique case (rcnt)
                2'd0: host <= mem_rdata[ADDR_W-1:0];
                2'd1: loc  <= mem_rdata[ADDR_W-1:0];
                2'd2: remw <= mem_rdata[CNT_W-1:2];
                default: begin
                  nxt_base <= mem_rdata[ADDR_W-1:4];
                  nxt_irq  <= mem_rdata[NF_IRQ];
                  state    <= (remw == '0) ? ST_TERM : ST_XFER;
                end
              endcase
            end
          end
          ST_XFER: begin
            if (src_ready) begin
              mem_wr    <= 1'b1;
              mem_addr  <= host;
              mem_wdata <= src_data;
              host      <= host + ADDR_W'(STEP);
              remw      <= remw - 1'b1;
              if (remw == WC_W'(1))
                state <= ST_TERM;
            end
          end
          default: begin
            ptr   <= {nxt_base, 4'b0000};
            icnt  <= '0;
            rcnt  <= '0;
            state <= ST_FETCH;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/desc_ring_dma.sv
module desc_ring_dma
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_pop,
  output logic [ADDR_W-1:0] src_addr
);

  logic              run_en;
  logic              start_req;
  logic              abort_req;
  logic              tc_set;
  logic              busy;
  logic [ADDR_W-1:0] first_desc;
  logic [ADDR_W-1:0] cur_host;
  logic [ADDR_W-1:0] cur_desc;

  desc_ring_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .cur_host   (cur_host),
    .cur_desc   (cur_desc),
    .tc_set     (tc_set),
    .run_en     (run_en),
    .start_req  (start_req),
    .abort_req  (abort_req),
    .first_desc (first_desc),
    .irq        (irq),
    .cfg_rdata  (cfg_rdata)
  );

  desc_ring_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .start_req  (start_req),
    .abort_req  (abort_req),
    .first_desc (first_desc),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .src_ready  (src_ready),
    .src_data   (src_data),
    .src_pop    (src_pop),
    .src_addr   (src_addr),
    .tc_set     (tc_set),
    .busy       (busy),
    .cur_host   (cur_host),
    .cur_desc   (cur_desc)
  );

endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [1:0]        ctl_bits,
  input logic              irq,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              src_ready,
  input logic              src_pop,
  input logic [ADDR_W-1:0] src_addr
);

  logic ctl_wr;
  assign ctl_wr = cfg_we && (cfg_addr == 2'd0);

  AST_POP_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    src_pop |-> src_ready);                                            // R4
  AST_WRITE_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    src_pop |=> mem_wr);                                               // R4
  AST_HOST_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + 4)); // R3
  AST_LOCAL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (src_pop && $past(src_pop)) |-> $stable(src_addr));                // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctl_wr && ctl_bits[0])) |=> irq);                        // R7
  AST_ABORT_HALT: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_bits[1]) |=> (!src_pop && !mem_wr));                // R11

endmodule

bind desc_ring_dma desc_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .ctl_bits  (cfg_wdata[3:2]),
  .irq       (irq),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .src_ready (src_ready),
  .src_pop   (src_pop),
  .src_addr  (src_addr)
);

// File: tb/sim_desc_ring_dma.sv
`timescale 1ns/1ps
module sim_desc_ring_dma;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        irq;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        src_ready;
  logic [31:0] src_data;
  logic        src_pop;
  logic [31:0] src_addr;

  always #2.5 clk = ~clk;

  desc_ring_dma u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_ready(src_ready),
    .src_data(src_data), .src_pop(src_pop), .src_addr(src_addr)
  );

  logic [31:0] mem [0:255];
  logic [31:0] pop_cnt;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  always @(posedge clk) begin
    if (rst) pop_cnt <= 32'd0;
    else if (src_pop) pop_cnt <= pop_cnt + 32'd1;
  end
  assign src_data = 32'hA500_0000 + pop_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  int gidx   = 0;
  bit exp_irq = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] exp_addr(input bit ring_b, input int w);
    int j;
    if (!ring_b) return 32'h100 + 32'(4 * (w % 4));
    j = w % 5;
    if (j < 2) return 32'h200 + 32'(4 * j);
    return 32'h300 + 32'(4 * (j - 2));
  endfunction

  // ring_b=0: one self-looping 16-byte descriptor, no interrupt flag
  // ring_b=1: 8-byte (irq), 0-byte, 12-byte (irq) descriptors in a ring
  task automatic run_phase(input int nwrites, input bit ring_b);
    int  widx = 0;
    bit  prev_collide = 1'b0;
    while (widx < nwrites) begin
      bit tc_now = 1'b0;
      bit collide = 1'b0;
      bit clr;
      @(negedge clk);
      cfg_we = 1'b0;
      src_ready = ($urandom_range(99, 0) < 60);
      chk(prev_collide ? "R13" : "R6", {31'd0, irq}, {31'd0, exp_irq});
      prev_collide = 1'b0;
      if (mem_wr) begin
        int j = widx % 5;
        string tg;
        if (!ring_b) tg = "R3";
        else if (widx >= 5) tg = "R10";
        else if (j < 2) tg = "R9";
        else tg = "R8";
        chk(tg, mem_addr, exp_addr(ring_b, widx));
        chk("R4", mem_wdata, 32'hA500_0000 + 32'(gidx));
        chk("R5", src_addr, ring_b ? 32'h40 : 32'h44);
        if (ring_b && (j == 1 || j == 4)) begin
          tc_now = 1'b1;
          collide = ((widx / 5) % 2 == 0);
        end
        widx++;
        gidx++;
        if (widx == nwrites) src_ready = 1'b0;
      end
      clr = irq || collide;
      if (clr) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h5;
      end
      prev_collide = collide;
      exp_irq = tc_now ? 1'b1 : (clr ? 1'b0 : exp_irq);
    end
  endtask

  task automatic abort_and_check(input logic [31:0] exp_host);
    logic [31:0] rd;
    cfg_write(2'd0, 32'h8);
    src_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R11", {30'd0, src_pop, mem_wr}, 32'd0);
    end
    src_ready = 1'b0;
    cfg_read(2'd0, rd);
    chk("R11", rd & 32'h21, 32'h0);
    cfg_read(2'd2, rd);
    chk("R12", rd, exp_host);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      report();
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 32'd0;
    src_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    // ring A at 0x0C0: host 0x100, local 0x44, 16 bytes, self link, flags 0x9
    mem[8'h30] = 32'h100; mem[8'h31] = 32'h44; mem[8'h32] = 32'd16; mem[8'h33] = 32'h0C9;
    // ring B at 0x080 / 0x090 / 0x0A0
    mem[8'h20] = 32'h200; mem[8'h21] = 32'h40; mem[8'h22] = 32'd8;  mem[8'h23] = 32'h09D;
    mem[8'h24] = 32'h280; mem[8'h25] = 32'h48; mem[8'h26] = 32'd0;  mem[8'h27] = 32'h0A9;
    mem[8'h28] = 32'h300; mem[8'h29] = 32'h40; mem[8'h2A] = 32'd12; mem[8'h2B] = 32'h08D;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {28'd0, irq, mem_rd, mem_wr, src_pop}, 32'd0);
    cfg_read(2'd0, rd);
    chk("R1", rd, 32'd0);

    // phase A: flag-free ring, irq must stay low
    cfg_write(2'd1, 32'h0C5);
    cfg_write(2'd0, 32'h3);
    cfg_read(2'd0, rd);
    chk("R2", rd, 32'h21);
    run_phase(10, 1'b0);
    abort_and_check(32'h108);

    // phase B: interrupting ring with a zero-length link and wrap
    exp_irq = 1'b0;
    cfg_write(2'd1, 32'h085);
    cfg_write(2'd0, 32'h3);
    cfg_read(2'd0, rd);
    chk("R2", rd, 32'h21);
    run_phase(23, 1'b1);
    abort_and_check(32'h304);

    // directed: write without clear bit keeps irq, then clear drops it
    cfg_write(2'd1, 32'h080);
    cfg_write(2'd0, 32'h3);
    src_ready = 1'b1;
    for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
    src_ready = 1'b0;
    chk("R6", {31'd0, irq}, 32'd1);
    cfg_write(2'd0, 32'h1);
    chk("R7", {31'd0, irq}, 32'd1);
    cfg_write(2'd0, 32'h5);
    chk("R7", {31'd0, irq}, 32'd0);
    cfg_write(2'd0, 32'h0);
    src_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", {31'd0, src_pop}, 32'd0);

    done = 1'b1;
    report();
  end

endmodule